// File: doc/BRIEF.md
# Parallel EPROM Read Bus Controller

This block is a synchronous controller that fetches single bytes from an external asynchronous 32K x 8 read-only memory. A host raises `req` with a 15-bit address. The controller drives the memory address and the active-low chip-select and output-gate pins. It holds them for a number of clock cycles derived from the memory's access-time limits, then samples the data bus. It returns the byte on `rdata` together with a one-cycle `rvalid` strobe, and `busy` covers the period in between.

All wait counts come from parameters: the clock period in ns and four memory limits. These are the address access time, the chip-select access time, the output-gate access time and the output float time. Each access limit becomes `ceil(limit / period) + 1` cycles, and the extra cycle gives the capture margin. On a wake from standby, the output gate is lowered late, after `floor((tCE - tOE) / period)` cycles, which still keeps within the chip-select access time. Reads that follow one another keep chip select low and only move the address. After a run of idle cycles the controller raises both pins. It then holds them high for a float guard of `ceil(tOFF / period)` cycles, so the data bus is released before the memory is selected again.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and right after reset, `mem_ce_n` and `mem_oe_n` are 1, and `busy`, `rvalid` and `rdata` are 0.
- R2: A request accepted in standby lowers `mem_ce_n` at the accepting edge. It lowers `mem_oe_n` OE_LAG cycles later (default 4). `rvalid` rises STBY_WAIT clock edges after the accepting edge (default 9).
- R3: A request accepted while the memory is selected and idle keeps `mem_ce_n` low for the whole access. It drives the new address at the accepting edge, and `rvalid` rises ACC_CYC edges later (default 9).
- R4: `rvalid` is high for exactly one cycle. `rdata` carries the byte present on `mem_data` at the capture edge and holds it until the next capture.
- R5: `busy` is high from the accepting edge until the capture edge, and it is low whenever `rvalid` is high.
- R6: A `req` (with any `addr`) that arrives while `busy` is high is ignored. It does not change the address in flight, the returned byte or the number of `rvalid` pulses.
- R7: While `busy` is high and `mem_ce_n` is low, `mem_addr` does not change.
- R8: After IDLE_LIMIT consecutive cycles in the selected-idle state with no request (default 8), `mem_ce_n` and `mem_oe_n` both go high at the same edge.
- R9: After such a release, `mem_ce_n` stays high for at least OFF_CYC cycles (default 3). A request that arrives during this guard is accepted (`busy` rises), and its access starts at the edge where the guard ends.
- R10: `mem_oe_n` is low only while `mem_ce_n` is low.
- R11: The wait counts follow the formulas: ACC_CYC = ceil(tACC/T)+1, CE_CYC = ceil(tCE/T)+1, OE_CYC = ceil(tOE/T)+1, OE_LAG = floor((tCE-tOE)/T), STBY_WAIT = max(ACC_CYC, CE_CYC, OE_LAG+OE_CYC), OFF_CYC = max(ceil(tOFF/T),1). With the defaults (T=20, tACC=tCE=150, tOE=65, tOFF=50) these give 9, 9, 5, 4, 9 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, sampled on each rising edge |
| addr | input | 15 | Byte address sampled with an accepted request |
| busy | output | 1 | High while an accepted read is outstanding |
| rvalid | output | 1 | One-cycle strobe marking `rdata` as new |
| rdata | output | 8 | Captured byte |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip select to the memory |
| mem_oe_n | output | 1 | Active-low output gate to the memory |
| mem_data | input | 8 | Data bus from the memory |

## Verification
The assertions assume that the host drops `req` after an acceptance or leaves it up only during `busy`. They also assume that the memory parameters are positive, so that every access wait is at least two cycles and a strobe can never merge with the next one. The stimulus holds `req` for exactly one accepting edge. Its only other pulses are deliberate ones during `busy`, meant to show that they are ignored. Random idle gaps range from zero to well past IDLE_LIMIT, so accesses start from standby, from the float guard and from the selected-idle state. A behavioural memory stub measures real elapsed time since each pin or address change, and it returns inverted data if any access limit has not yet passed at the sampling edge.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and constant helpers for the EPROM read controller.
// Assumes all timing arguments are non-negative and divisors are non-zero.
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_FLOAT   = 2'd3
    } rd_state_e;

    // Integer division rounded up.
    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two values.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_cycle_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter that stops at zero.
// Assumes a load value fits in CW bits; load takes priority over counting.
module eprom_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          zero
);

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Flag the terminal count.
    always_comb zero = (count == '0);

endmodule

// File: rtl/eprom_idle_watch.sv
`timescale 1ns/1ps
// Module: counts consecutive cycles with run high and flags the LIMIT-th one.
// Assumes LIMIT >= 1; the count clears on any cycle where run is low.
module eprom_idle_watch #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int IW = $clog2(LIMIT + 1);

    logic [IW-1:0] idle_cnt;

    // Expire on the cycle that completes LIMIT idle cycles.
    always_comb expired = run && (idle_cnt == IW'(LIMIT - 1));

    // Track the length of the current idle run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!run || expired) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
// Module: read controller for an external asynchronous 32K x 8 read-only memory.
// Takes one-cycle host requests, sequences the chip-select and output-gate pins,
// waits cycle counts derived from the memory limits, and returns the byte with a
// one-cycle strobe. It goes to standby after an idle run, and it holds a float
// guard before the memory is selected again.
// Assumes the host pulses req only while busy is low; req during busy is ignored.
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ACC_NS      = 150,
    parameter int T_CE_NS       = 150,
    parameter int T_OE_NS       = 65,
    parameter int T_OFF_NS      = 50,
    parameter int IDLE_LIMIT    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int unsigned ACC_CYC   = cdiv(T_ACC_NS, CLK_PERIOD_NS) + 1;
    localparam int unsigned CE_CYC    = cdiv(T_CE_NS, CLK_PERIOD_NS) + 1;
    localparam int unsigned OE_CYC    = cdiv(T_OE_NS, CLK_PERIOD_NS) + 1;
    localparam int unsigned OE_LAG    = (T_CE_NS > T_OE_NS) ?
                                        (T_CE_NS - T_OE_NS) / CLK_PERIOD_NS : 0;
    localparam int unsigned STBY_WAIT = max2(max2(ACC_CYC, CE_CYC), OE_LAG + OE_CYC);
    localparam int unsigned OFF_CYC   = max2(cdiv(T_OFF_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned MAX_WAIT  = max2(STBY_WAIT, OFF_CYC);
    localparam int          CW        = $clog2(MAX_WAIT + 1);
    localparam int unsigned OE_AT     = STBY_WAIT - OE_LAG;
    localparam logic        OE_FIRST  = (OE_LAG == 0) ? 1'b0 : 1'b1;

    rd_state_e     state;
    logic          pend;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tmr_count;
    logic          tmr_zero;
    logic          idle_run;
    logic          idle_exp;
    logic          start_stby;
    logic          start_act;
    logic          go_float;

    // Shared wait timer for access and float guard windows.
    eprom_cycle_timer #(.CW(CW)) wait_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .zero     (tmr_zero)
    );

    // Idle-run watcher that triggers the move to standby.
    eprom_idle_watch #(.LIMIT(IDLE_LIMIT)) idle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (idle_run),
        .expired (idle_exp)
    );

    // Decode the access starts and the release decision of this cycle.
    always_comb begin
        idle_run   = (state == ST_ACTIVE) && !req;
        start_stby = ((state == ST_STANDBY) && req) ||
                     ((state == ST_FLOAT) && tmr_zero && (pend || req));
        start_act  = (state == ST_ACTIVE) && req;
        go_float   = (state == ST_ACTIVE) && idle_exp;
    end

    // Pick the timer load for the window that starts at this edge.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start_stby) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(STBY_WAIT - 1);
        end else if (start_act) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(ACC_CYC - 1);
        end else if (go_float) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(OFF_CYC - 1);
        end
    end

    // Main sequencer: pins, host handshake and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_STANDBY;
            pend     <= 1'b0;
            busy     <= 1'b0;
            rvalid   <= 1'b0;
            rdata    <= '0;
            mem_addr <= '0;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
        end else begin
            rvalid <= 1'b0;
            unique case (state)
                ST_STANDBY: begin
                    if (start_stby) begin
                        state    <= ST_ACCESS;
                        mem_addr <= addr;
                        busy     <= 1'b1;
                        mem_ce_n <= 1'b0;
                        mem_oe_n <= OE_FIRST;
                    end
                end
                ST_ACCESS: begin
                    if (tmr_zero) begin
                        state  <= ST_ACTIVE;
                        rdata  <= mem_data;
                        rvalid <= 1'b1;
                        busy   <= 1'b0;
                    end else if (tmr_count == CW'(OE_AT)) begin
                        mem_oe_n <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    if (start_act) begin
                        state    <= ST_ACCESS;
                        mem_addr <= addr;
                        busy     <= 1'b1;
                    end else if (go_float) begin
                        state    <= ST_FLOAT;
                        pend     <= 1'b0;
                        mem_ce_n <= 1'b1;
                        mem_oe_n <= 1'b1;
                    end
                end
                ST_FLOAT: begin
                    if (start_stby) begin
                        state    <= ST_ACCESS;
                        pend     <= 1'b0;
                        busy     <= 1'b1;
                        mem_ce_n <= 1'b0;
                        mem_oe_n <= OE_FIRST;
                        if (!pend) begin
                            mem_addr <= addr;
                        end
                    end else if (tmr_zero) begin
                        state <= ST_STANDBY;
                    end else if (req && !pend) begin
                        pend     <= 1'b1;
                        busy     <= 1'b1;
                        mem_addr <= addr;
                    end
                end
                default: state <= ST_STANDBY;
            endcase
        end
    end

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for eprom_rd_ctrl, attached by bind.
// Assumes the same clock period and float limit parameters as the checked block.
module eprom_rd_ctrl_chk
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_OFF_NS      = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rvalid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr
);

    localparam int unsigned OFF_CYC = max2(cdiv(T_OFF_NS, CLK_PERIOD_NS), 1);
    localparam int          HW      = $clog2(OFF_CYC + 1);

    logic [HW-1:0] hi_cnt;

    // Saturating count of cycles spent with chip select high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HW'(OFF_CYC);
        end else if (!mem_ce_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HW'(OFF_CYC)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n); // R10

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R4

    AST_BUSY_LOW_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !busy); // R5

    AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(busy)); // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ce_n) |=> $stable(mem_addr)); // R7

    AST_FLOAT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_cnt >= HW'(OFF_CYC))); // R9

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_OFF_NS      (T_OFF_NS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rvalid   (rvalid),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr)
);

// File: tb/eprom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed and seeded-random reads against a timing-aware memory stub.
module eprom_rd_ctrl_tb_top;

    localparam int AW   = 15;
    localparam int DW   = 8;
    localparam int PER  = 20;
    localparam int TACC = 150;
    localparam int TCE  = 150;
    localparam int TOE  = 65;
    localparam int TOFF = 50;
    localparam int IDLE = 8;

    function automatic int cup(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    localparam int E_ACC  = cup(TACC, PER) + 1;
    localparam int E_CE   = cup(TCE, PER) + 1;
    localparam int E_OE   = cup(TOE, PER) + 1;
    localparam int E_LAG  = (TCE - TOE) / PER;
    localparam int E_S0   = (E_ACC > E_CE) ? E_ACC : E_CE;
    localparam int E_STBY = (E_S0 > E_LAG + E_OE) ? E_S0 : E_LAG + E_OE;
    localparam int E_OFF  = (cup(TOFF, PER) > 1) ? cup(TOFF, PER) : 1;

    logic          clk;
    logic          rst_n;
    logic          req;
    logic [AW-1:0] addr;
    logic          busy;
    logic          rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic [DW-1:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int hi_run = 0;
    realtime t_addr = 0.0;
    realtime t_ce   = 0.0;
    realtime t_oe   = 0.0;
    realtime t_smp;

    eprom_rd_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER), .T_ACC_NS(TACC),
        .T_CE_NS(TCE), .T_OE_NS(TOE), .T_OFF_NS(TOFF), .IDLE_LIMIT(IDLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
        .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data)
    );

    initial clk = 1'b0;
    always #(PER / 2) clk = ~clk;

    // Memory content as a function of the address.
    function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
        return (a[7:0] ^ {a[14:8], 1'b0}) + 8'h5A;
    endfunction

    // Stub: timestamps of the last change on each input of the memory.
    always @(mem_addr) t_addr = $realtime;
    always @(negedge mem_ce_n) t_ce = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;

    // Stub: drive data for the coming edge, inverted if any limit is unmet.
    always @(negedge clk) begin
        t_smp = $realtime + PER / 2.0;
        if (!mem_ce_n && !mem_oe_n) begin
            if ((t_smp - t_addr >= TACC) && (t_smp - t_ce >= TCE) && (t_smp - t_oe >= TOE))
                mem_data = mem_byte(mem_addr);
            else
                mem_data = ~mem_byte(mem_addr);
        end else begin
            mem_data = '0;
        end
    end

    // Length of the current run of cycles with chip select high.
    always @(negedge clk) begin
        if (mem_ce_n) hi_run = hi_run + 1;
        else          hi_run = 0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary_and_finish();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary_and_finish();
        end
    end

    // One read; poke adds a stray request during busy (must be ignored).
    task automatic do_read(input logic [AW-1:0] a, input bit poke);
        int  lat_exp;
        int  n;
        int  ce_idx;
        int  oe_idx;
        int  wait_ce;
        bit  start_low;
        bit  ce_rose;
        bit  addr_bad;
        bit  busy_gap;
        logic [DW-1:0] held;
        @(negedge clk);
        #1;
        start_low = !mem_ce_n;
        wait_ce   = (!start_low && hi_run < E_OFF) ? (E_OFF - hi_run) : 0;
        lat_exp   = start_low ? E_ACC : E_STBY + wait_ce;
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req  = 1'b0;
        addr = AW'($urandom);
        n = 0; ce_idx = -1; oe_idx = -1;
        ce_rose = 0; addr_bad = 0; busy_gap = 0;
        while (!rvalid && n < 200) begin
            if (ce_idx < 0 && !mem_ce_n) ce_idx = n;
            if (oe_idx < 0 && !mem_oe_n) oe_idx = n;
            if (start_low && mem_ce_n) ce_rose = 1;
            if (!mem_ce_n && mem_addr != a) addr_bad = 1;
            if (!busy) busy_gap = 1;
            if (poke && n == 2) begin req = 1'b1; addr = ~a; end
            if (poke && n == 3) req = 1'b0;
            @(negedge clk);
            n++;
        end
        #1;
        check(n == lat_exp, start_low ? "R3 R11 latency" : "R2 R11 latency", n, lat_exp);
        check(rdata == mem_byte(a), poke ? "R6 data" : "R4 data", rdata, mem_byte(a));
        check(!busy_gap && !busy, "R5 busy window", busy_gap, 0);
        check(!addr_bad, "R7 address held", addr_bad, 0);
        if (start_low) begin
            check(!ce_rose, "R3 chip select stays low", ce_rose, 0);
        end else begin
            check(ce_idx == wait_ce, "R2 R9 chip select fall", ce_idx, wait_ce);
            check(oe_idx == wait_ce + E_LAG, "R2 output gate lag", oe_idx, wait_ce + E_LAG);
        end
        held = rdata;
        @(negedge clk);
        #1;
        check(!rvalid, "R4 single strobe", rvalid, 0);
        check(rdata == held, "R4 data held", rdata, held);
        if (poke) check(!busy, "R6 stray request not taken", busy, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        req   = 1'b0;
        addr  = '0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && !busy && !rvalid && rdata == '0,
              "R1 reset state", {mem_ce_n, mem_oe_n, busy, rvalid}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(mem_ce_n && mem_oe_n && !busy && !rvalid,
              "R1 after release", {mem_ce_n, mem_oe_n, busy, rvalid}, 4'b1100);
        check(E_ACC == 9 && E_LAG == 4 && E_STBY == 9 && E_OFF == 3,
              "R11 derived counts", E_STBY, 9);

        // Wake from standby, then reads from the selected-idle state.
        do_read(15'h1234, 1'b0);
        do_read(15'h7FFF, 1'b0);
        do_read(15'h0000, 1'b0);
        // Stray request during busy.
        do_read(15'h2A55, 1'b1);

        // Idle run leads to release of both pins.
        for (int j = 2; j <= IDLE; j++) begin
            @(negedge clk);
            #1;
            if (j < IDLE)
                check(!mem_ce_n, "R8 selected before limit", mem_ce_n, 0);
            else
                check(mem_ce_n && mem_oe_n, "R8 release at limit",
                      {mem_ce_n, mem_oe_n}, 2'b11);
        end
        // Request inside the float guard is held until the guard ends.
        do_read(15'h0F0F, 1'b0);

        // Let the guard run out, then wake from standby.
        repeat (IDLE + E_OFF + 4) @(negedge clk);
        #1;
        check(mem_ce_n && mem_oe_n && !busy, "R8 standby reached",
              {mem_ce_n, mem_oe_n, busy}, 3'b110);
        do_read(15'h4321, 1'b0);

        // Seeded random reads with idle gaps on both sides of the limit.
        for (int i = 0; i < 60; i++) begin
            int gap;
            gap = $urandom_range(0, IDLE + E_OFF + 3);
            repeat (gap) @(negedge clk);
            do_read(AW'($urandom), (i % 7) == 3);
        end

        summary_and_finish();
    end

endmodule